// File: doc/BRIEF.md
# Programmable Memory Chip-Select Decoder

This block turns each bus cycle's 20-bit address into a set of active-low chip-selects. The address is assembled from a 4-bit high part and a 16-bit low part. It is captured, together with a flag that marks the cycle as a memory or an I/O cycle, on the clock edge where the address latch enable strobe is high. The selects computed from that captured address stay steady until the next strobe, so the external devices see one stable select for the whole bus cycle.

There are four families of select:

- **Top region:** pinned to the top of memory.
- **Bottom region:** pinned to address zero.
- **Movable block:** a block whose base is set by software, split into four equal quarter-selects.
- **Peripheral group:** seven peripheral selects sitting in 128-byte windows above a programmable base, either in memory space or in I/O space.

Sizes are powers of two. Each decode is therefore a masked equality on the address bits above the block size. Every select is worked out on its own, with no priority between regions.

Configuration goes in through a one-cycle write port, which uses the following register addresses:

| Register address | Contents |
|---|---|
| 0 | top region |
| 1 | bottom region |
| 2 | movable block size |
| 3 | movable block base |
| 4 | peripheral group |
| 5 to 7 | unused |

Top module: `memSelectDecoder`

## Requirements
- R1: After reset all selects are inactive (high). The top region alone is enabled, with a 1 KB size, so that a memory cycle at 0xFFC00..0xFFFFF asserts the top select. A memory cycle at 0xFFBFF or 0x00000 asserts nothing.
- R2: Writing register 0 sets the top region: data[3:0] is a size code k giving 1 KB·2^k, and data[15] is the enable. Codes above 8 act as 8 (256 KB). The select is active for memory addresses from 2^20 − size up to 0xFFFFF.
- R3: Writing register 1 sets the bottom region, using the same encoding and clamp as R2. The select is active for memory addresses from 0 up to size − 1, and is never active while data[15] is clear.
- R4: Register 2 sets the movable block: data[3:0] is a code k giving 8 KB·2^k, clamped at 6 (512 KB), and data[15] is the enable. Register 3 data[9:0] gives base address bits [19:10]. Base bits below the block size are ignored.
- R5: Within the movable block, quarter-select i is active for the i-th contiguous quarter (i = 0..3, from the lowest address upward). At most one quarter-select is active at a time.
- R6: The top, bottom and movable selects never assert for an I/O cycle.
- R7: Register 4 sets the peripheral group: data[9:0] is base bits [19:10], data[14] selects I/O space, and data[15] is the enable. Select n (0..6) is active for offsets n·128..n·128+127 from the base. Offsets 896..1023 assert nothing. At most one peripheral select is active at a time.
- R8: In memory mode the peripheral selects answer only memory cycles and compare address bits [19:10]. In I/O mode they answer only I/O cycles and compare address bits [15:10] with base bits [5:0], ignoring address bits [19:16].
- R9: Address and cycle type are captured on a rising clock edge with the strobe high. The selects reflect them from that edge on, and hold while the strobe is low, even if the address inputs change.
- R10: Overlapping regions each assert their own select in the same cycle.
- R11: Writes to register addresses 5 to 7 change no decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addrHigh | input | 4 | Address bits [19:16] |
| addrLow | input | 16 | Address bits [15:0] from the multiplexed bus |
| ale | input | 1 | Address latch enable; captures address and cycle type |
| isMem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgData | input | 16 | Configuration write data |
| upperSelN | output | 1 | Top region select, active low |
| lowerSelN | output | 1 | Bottom region select, active low |
| midSelN | output | 4 | Movable block quarter-selects, active low |
| periSelN | output | 7 | Peripheral selects, active low |

## Verification
Two things can happen in the same cycle: the movable block can overlap the bottom region, so both selects fire on one address, and a captured address can hold while the address pins wander. The bench provokes the overlap by placing the movable block at base zero inside the bottom region. It then expects both the bottom select and the correct quarter-select on one latched address. The hold case is provoked by changing the address and cycle-type inputs after capture with the strobe low. The judgement is that every select still matches the captured address, not the new pins.

// File: rtl/memSelPkg.sv
package memSelPkg;
  localparam int ADDR_W        = 20;
  localparam int HIGH_W        = 4;
  localparam int LOW_W         = ADDR_W - HIGH_W;
  localparam int CFG_W         = 16;
  localparam int CFG_AW        = 3;
  localparam int CODE_W        = 4;
  localparam int BASE_LSB      = 10;
  localparam int BASE_W        = ADDR_W - BASE_LSB;
  localparam int IO_BASE_W     = LOW_W - BASE_LSB;
  localparam int UL_MIN_BITS   = 10;
  localparam int UL_MAX_CODE   = 8;
  localparam int MID_MIN_BITS  = 13;
  localparam int MID_MAX_CODE  = 6;
  localparam int NUM_MID       = 4;
  localparam int MID_IDX_W     = $clog2(NUM_MID);
  localparam int NUM_PERI      = 7;
  localparam int PERI_WIN_BITS = 7;
  localparam int PERI_IDX_W    = BASE_LSB - PERI_WIN_BITS;
  localparam int EN_BIT        = 15;
  localparam int IO_BIT        = 14;

  localparam logic [CFG_AW-1:0] REG_UPPER    = 3'd0;
  localparam logic [CFG_AW-1:0] REG_LOWER    = 3'd1;
  localparam logic [CFG_AW-1:0] REG_MID_SIZE = 3'd2;
  localparam logic [CFG_AW-1:0] REG_MID_BASE = 3'd3;
  localparam logic [CFG_AW-1:0] REG_PERI     = 3'd4;

  typedef struct packed {
    logic latchAddr;
    logic wrUpper;
    logic wrLower;
    logic wrMidSize;
    logic wrMidBase;
    logic wrPeri;
  } strobeT;
endpackage

// File: rtl/memSelCtrl.sv
module memSelCtrl
  import memSelPkg::*;
(
  input  logic              ale,
  input  logic              cfgWrEn,
  input  logic [CFG_AW-1:0] cfgAddr,
  output strobeT            strobes
);
  always_comb begin
    strobes           = '0;
    strobes.latchAddr = ale;
    if (cfgWrEn) begin
      unique case (cfgAddr)
        REG_UPPER:    strobes.wrUpper   = 1'b1;
        REG_LOWER:    strobes.wrLower   = 1'b1;
        REG_MID_SIZE: strobes.wrMidSize = 1'b1;
        REG_MID_BASE: strobes.wrMidBase = 1'b1;
        REG_PERI:     strobes.wrPeri    = 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/memSelDatapath.sv
module memSelDatapath
  import memSelPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobes,
  input  logic [HIGH_W-1:0]   addrHigh,
  input  logic [LOW_W-1:0]    addrLow,
  input  logic                isMem,
  input  logic [CFG_W-1:0]    cfgData,
  output logic                upperSelN,
  output logic                lowerSelN,
  output logic [NUM_MID-1:0]  midSelN,
  output logic [NUM_PERI-1:0] periSelN
);
  function automatic logic [CODE_W-1:0] clampCode(input logic [CODE_W-1:0] code,
                                                  input int maxCode);
    return (int'(code) > maxCode) ? CODE_W'(maxCode) : code;
  endfunction

  function automatic logic [ADDR_W-1:0] highMask(input int lowBits);
    return ~((ADDR_W'(1) << lowBits) - ADDR_W'(1));
  endfunction

  logic [CODE_W-1:0] upperCode, lowerCode, midCode;
  logic              upperEn, lowerEn, midEn, periEn, periIo;
  logic [BASE_W-1:0] midBase, periBase;
  logic [ADDR_W-1:0] latAddr;
  logic              latMem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperCode <= '0;
      upperEn   <= 1'b1;
      lowerCode <= '0;
      lowerEn   <= 1'b0;
      midCode   <= '0;
      midEn     <= 1'b0;
      midBase   <= '0;
      periBase  <= '0;
      periEn    <= 1'b0;
      periIo    <= 1'b0;
      latAddr   <= '0;
      latMem    <= 1'b0;
    end else begin
      if (strobes.wrUpper) begin
        upperCode <= clampCode(cfgData[CODE_W-1:0], UL_MAX_CODE);
        upperEn   <= cfgData[EN_BIT];
      end
      if (strobes.wrLower) begin
        lowerCode <= clampCode(cfgData[CODE_W-1:0], UL_MAX_CODE);
        lowerEn   <= cfgData[EN_BIT];
      end
      if (strobes.wrMidSize) begin
        midCode <= clampCode(cfgData[CODE_W-1:0], MID_MAX_CODE);
        midEn   <= cfgData[EN_BIT];
      end
      if (strobes.wrMidBase) midBase <= cfgData[BASE_W-1:0];
      if (strobes.wrPeri) begin
        periBase <= cfgData[BASE_W-1:0];
        periIo   <= cfgData[IO_BIT];
        periEn   <= cfgData[EN_BIT];
      end
      if (strobes.latchAddr) begin
        latAddr <= {addrHigh, addrLow};
        latMem  <= isMem;
      end
    end
  end

  logic [ADDR_W-1:0]     upperMask, lowerMask, midMask, midBaseFull;
  logic                  upperHit, lowerHit, midHit, periHit;
  logic                  periSpaceOk, periBaseOk;
  logic [MID_IDX_W-1:0]  midQuarter;
  logic [PERI_IDX_W-1:0] periIdx;
  int                    midBits;

  always_comb begin
    upperMask   = highMask(UL_MIN_BITS + int'(upperCode));
    lowerMask   = highMask(UL_MIN_BITS + int'(lowerCode));
    midBits     = MID_MIN_BITS + int'(midCode);
    midMask     = highMask(midBits);
    midBaseFull = {midBase, {BASE_LSB{1'b0}}};

    upperHit   = upperEn && latMem && ((latAddr & upperMask) == upperMask);
    lowerHit   = lowerEn && latMem && ((latAddr & lowerMask) == '0);
    midHit     = midEn && latMem && ((latAddr & midMask) == (midBaseFull & midMask));
    midQuarter = MID_IDX_W'(latAddr >> (midBits - MID_IDX_W));

    periSpaceOk = periIo ? !latMem : latMem;
    periBaseOk  = periIo
                ? (latAddr[LOW_W-1:BASE_LSB] == periBase[IO_BASE_W-1:0])
                : (latAddr[ADDR_W-1:BASE_LSB] == periBase);
    periHit     = periEn && periSpaceOk && periBaseOk;
    periIdx     = latAddr[BASE_LSB-1:PERI_WIN_BITS];
  end

  assign upperSelN = !upperHit;
  assign lowerSelN = !lowerHit;

  for (genvar q = 0; q < NUM_MID; q++) begin : gMid
    assign midSelN[q] = !(midHit && (midQuarter == MID_IDX_W'(q)));
  end

  for (genvar n = 0; n < NUM_PERI; n++) begin : gPeri
    assign periSelN[n] = !(periHit && (periIdx == PERI_IDX_W'(n)));
  end
endmodule

// File: rtl/memSelectDecoder.sv
module memSelectDecoder
  import memSelPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [HIGH_W-1:0]   addrHigh,
  input  logic [LOW_W-1:0]    addrLow,
  input  logic                ale,
  input  logic                isMem,
  input  logic                cfgWrEn,
  input  logic [CFG_AW-1:0]   cfgAddr,
  input  logic [CFG_W-1:0]    cfgData,
  output logic                upperSelN,
  output logic                lowerSelN,
  output logic [NUM_MID-1:0]  midSelN,
  output logic [NUM_PERI-1:0] periSelN
);
  strobeT strobes;

  memSelCtrl uCtrl (
    .ale     (ale),
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .strobes (strobes)
  );

  memSelDatapath uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .addrHigh  (addrHigh),
    .addrLow   (addrLow),
    .isMem     (isMem),
    .cfgData   (cfgData),
    .upperSelN (upperSelN),
    .lowerSelN (lowerSelN),
    .midSelN   (midSelN),
    .periSelN  (periSelN)
  );
endmodule

// File: rtl/memSelectDecoderChecker.sv
module memSelectDecoderChecker
  import memSelPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                ale,
  input logic                isMem,
  input logic                cfgWrEn,
  input logic                upperSelN,
  input logic                lowerSelN,
  input logic [NUM_MID-1:0]  midSelN,
  input logic [NUM_PERI-1:0] periSelN
);
  // R6: an I/O cycle never drives a memory-only select
  assert_io_no_memsel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ale && !isMem) |=> (upperSelN && lowerSelN && (&midSelN)));

  // R5: quarter-selects are mutually exclusive
  assert_mid_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~midSelN));

  // R7: peripheral selects are mutually exclusive
  assert_peri_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~periSelN));

  // R9: with no capture and no write, every select holds
  assert_hold_selects_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!ale && !cfgWrEn) |=> ($stable(upperSelN) && $stable(lowerSelN)
                            && $stable(midSelN) && $stable(periSelN)));
endmodule

bind memSelectDecoder memSelectDecoderChecker uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .ale       (ale),
  .isMem     (isMem),
  .cfgWrEn   (cfgWrEn),
  .upperSelN (upperSelN),
  .lowerSelN (lowerSelN),
  .midSelN   (midSelN),
  .periSelN  (periSelN)
);

// File: tb/memSelectDecoder_test.sv
module memSelectDecoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 19;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  addrHigh = '0;
  logic [15:0] addrLow = '0;
  logic        ale = 1'b0;
  logic        isMem = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        upperSelN, lowerSelN;
  logic [3:0]  midSelN;
  logic [6:0]  periSelN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memSelectDecoder uut (
    .clk(clk), .rstN(rstN), .addrHigh(addrHigh), .addrLow(addrLow),
    .ale(ale), .isMem(isMem), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .upperSelN(upperSelN), .lowerSelN(lowerSelN),
    .midSelN(midSelN), .periSelN(periSelN)
  );

  // {isMem, address, upper, lower, mid[3:0], peri[6:0]} with active-high expectations
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 20'hFFFFF, 1'b1, 1'b0, 4'b0000, 7'b0000000},
    {1'b1, 20'hFF000, 1'b1, 1'b0, 4'b0000, 7'b0000000},
    {1'b1, 20'hFEFFF, 1'b0, 1'b0, 4'b0000, 7'b0000000},
    {1'b1, 20'h00000, 1'b0, 1'b1, 4'b0000, 7'b0000000},
    {1'b1, 20'h01FFF, 1'b0, 1'b1, 4'b0000, 7'b0000000},
    {1'b1, 20'h02000, 1'b0, 1'b0, 4'b0000, 7'b0000000},
    {1'b1, 20'h40000, 1'b0, 1'b0, 4'b0001, 7'b0000000},
    {1'b1, 20'h41234, 1'b0, 1'b0, 4'b0010, 7'b0000000},
    {1'b1, 20'h42FFF, 1'b0, 1'b0, 4'b0100, 7'b0000000},
    {1'b1, 20'h43800, 1'b0, 1'b0, 4'b1000, 7'b0000000},
    {1'b1, 20'h44000, 1'b0, 1'b0, 4'b0000, 7'b0000000},
    {1'b1, 20'h3FFFF, 1'b0, 1'b0, 4'b0000, 7'b0000000},
    {1'b1, 20'h80000, 1'b0, 1'b0, 4'b0000, 7'b0000001},
    {1'b1, 20'h8017F, 1'b0, 1'b0, 4'b0000, 7'b0000100},
    {1'b1, 20'h80300, 1'b0, 1'b0, 4'b0000, 7'b1000000},
    {1'b1, 20'h80380, 1'b0, 1'b0, 4'b0000, 7'b0000000},
    {1'b0, 20'hFFFFF, 1'b0, 1'b0, 4'b0000, 7'b0000000},
    {1'b0, 20'h00000, 1'b0, 1'b0, 4'b0000, 7'b0000000},
    {1'b0, 20'h80000, 1'b0, 1'b0, 4'b0000, 7'b0000000}
  };

  function automatic string vecTag(input int i);
    if (i < 3)  return "R2 top region";
    if (i < 6)  return "R3 bottom region";
    if (i < 12) return "R4/R5 movable quarters";
    if (i < 16) return "R7 peripheral windows";
    return "R6 io cycle ignored";
  endfunction

  task automatic writeCfg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic busCycle(input logic mem, input logic [19:0] a);
    @(negedge clk);
    {addrHigh, addrLow} = a; isMem = mem; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
  endtask

  task automatic checkSel(input string tag, input logic eu, input logic el,
                          input logic [3:0] em, input logic [6:0] ep);
    logic [12:0] act, exp;
    act = {~upperSelN, ~lowerSelN, ~midSelN, ~periSelN};
    exp = {eu, el, em, ep};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %013b expected %013b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkSel("R1 reset idle", 1'b0, 1'b0, 4'h0, 7'h00);
    busCycle(1'b1, 20'hFFC00); checkSel("R1 boot top", 1'b1, 1'b0, 4'h0, 7'h00);
    busCycle(1'b1, 20'hFFBFF); checkSel("R1 below boot", 1'b0, 1'b0, 4'h0, 7'h00);
    busCycle(1'b1, 20'h00000); checkSel("R1 bottom off", 1'b0, 1'b0, 4'h0, 7'h00);

    writeCfg(3'd0, 16'h8002);
    writeCfg(3'd1, 16'h8003);
    writeCfg(3'd2, 16'h8001);
    writeCfg(3'd3, 16'h0100);
    writeCfg(3'd4, 16'h8200);

    for (int i = 0; i < NVEC; i++) begin
      busCycle(VEC[i][33], VEC[i][32:13]);
      checkSel(vecTag(i), VEC[i][12], VEC[i][11], VEC[i][10:7], VEC[i][6:0]);
    end

    // R11: unused register addresses
    writeCfg(3'd5, 16'h0000);
    writeCfg(3'd6, 16'h0000);
    writeCfg(3'd7, 16'hFFFF);
    busCycle(1'b1, 20'hFFFFF); checkSel("R11 top intact", 1'b1, 1'b0, 4'h0, 7'h00);
    busCycle(1'b1, 20'h00000); checkSel("R11 bottom intact", 1'b0, 1'b1, 4'h0, 7'h00);

    // R4: base bits below block size ignored
    writeCfg(3'd3, 16'h0103);
    busCycle(1'b1, 20'h40000); checkSel("R4 base low bits", 1'b0, 1'b0, 4'h1, 7'h00);

    // R9: hold while strobe low and pins change
    @(negedge clk);
    {addrHigh, addrLow} = 20'hFFFFF; isMem = 1'b0;
    @(negedge clk);
    checkSel("R9 hold", 1'b0, 1'b0, 4'h1, 7'h00);

    // R2: size code clamp
    writeCfg(3'd0, 16'h800F);
    busCycle(1'b1, 20'hC0000); checkSel("R2 clamp inside", 1'b1, 1'b0, 4'h0, 7'h00);
    busCycle(1'b1, 20'hBFFFF); checkSel("R2 clamp outside", 1'b0, 1'b0, 4'h0, 7'h00);

    // R8: peripheral group in I/O space
    writeCfg(3'd4, 16'hC001);
    busCycle(1'b0, 20'hF0480); checkSel("R8 io select1", 1'b0, 1'b0, 4'h0, 7'h02);
    busCycle(1'b0, 20'h00400); checkSel("R8 io select0", 1'b0, 1'b0, 4'h0, 7'h01);
    busCycle(1'b1, 20'h00480); checkSel("R8 mem ignored", 1'b0, 1'b1, 4'h0, 7'h00);

    // R10: movable block overlapping bottom region
    writeCfg(3'd2, 16'h8000);
    writeCfg(3'd3, 16'h0000);
    busCycle(1'b1, 20'h01000); checkSel("R10 overlap", 1'b0, 1'b1, 4'h4, 7'h00);

    // R3: bottom region disabled
    writeCfg(3'd1, 16'h0003);
    busCycle(1'b1, 20'h00000); checkSel("R3 disabled", 1'b0, 1'b0, 4'h1, 7'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule